// File: doc/BRIEF.md
# Modem Control Status Tracker

This block keeps the modem handshake picture for every line of a multi-line serial multiplexer. The host writes a control word whose upper half holds one terminal-ready bit per line and whose lower half holds the per-line transmit enables. The block keeps a read-only status word with one ring bit and one carrier bit per line. It also keeps a connected flag for each line. Per-line event pulses from the line side mark a remote party arriving or leaving.

An arriving party on a line whose terminal-ready is low raises that line's ring bit. The host answers by raising terminal-ready, which turns the ring into carrier. An arrival on a line that is already terminal-ready goes straight to carrier. When auto-disconnect is on, lowering terminal-ready on a connected line hangs it up: a one-cycle hang-up pulse is issued and the line drops its connection and carrier. A modem-control enable gates all status updates, and a separate enable gates the hang-up action.

Every update is registered. The effect of the inputs sampled at one rising edge is visible on the outputs straight after that edge.

Top module: `modem_status_tracker`

## Requirements
- R1: The status word holds the ring bit of line i at bit i (bits 7:0) and the carrier bit of line i at bit 8+i (bits 15:8). After synchronous reset the status, the connected flags, the hang-up outputs and the control word are all zero.
- R2: A write with select 0 (control) stores the whole 16-bit word, whatever the modem-control enable is. Terminal-ready of line i is bit 8+i. The stored word appears on `ctl_q` after the next edge.
- R3: On a control write with modem control enabled, each carrier bit becomes its old value OR (new terminal-ready AND ring) for that line.
- R4: On a control write with modem control enabled, the ring bit of every line whose new terminal-ready is 1 is cleared.
- R5: With modem control and auto-disconnect both enabled, a control write that takes a connected line's terminal-ready from 1 to 0 drives that line's `hangup` bit high for exactly the next cycle. The same write clears the line's connected flag and carrier bit. With auto-disconnect off, no pulse is issued and the line stays connected.
- R6: An arrival pulse on an unconnected line sets its connected flag. With modem control enabled it also sets either carrier (if the line's terminal-ready, including a write in the same cycle, is 1) or ring (otherwise). An arrival on a line that is already connected is ignored.
- R7: With modem control enabled, the carrier bit of any line that is not connected is cleared. A leave pulse clears the connected flag and the carrier bit.
- R8: With modem control disabled, control writes are still stored and arrivals still set connected flags, but the status word does not change.
- R9: A write with select 1 (the status address) is ignored: neither the status word nor the control word changes.
- R10: A full-initialization pulse clears ring, carrier, connected flags, hang-up outputs and the control word at the next edge.
- R11: An arrival and a leave on the same line in the same cycle act as a leave: the line ends unconnected, and no ring or carrier is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_init | input | 1 | Full initialization pulse |
| mdm_en | input | 1 | Modem-control enable |
| auto_disc_en | input | 1 | Auto-disconnect enable |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 status address |
| wr_data | input | 16 | Host write data |
| conn_evt | input | 8 | Per-line remote arrival pulses |
| disc_evt | input | 8 | Per-line remote leave pulses |
| ctl_q | output | 16 | Stored control word |
| status_q | output | 16 | Status word: ring bits low, carrier bits high |
| conn_q | output | 8 | Per-line connected flags |
| hangup | output | 8 | Per-line hang-up pulses |

## Verification
Every result of this block (stored control word, ring and carrier bits, connected flags and hang-up pulses) is due exactly one rising edge after the inputs that cause it are sampled. No result takes longer. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares all four outputs on the following falling edge. It then returns the inputs to idle before the next vector. For the hang-up pulse, the idle vector that follows is also checked, to confirm the pulse lasts exactly one cycle.

// File: rtl/mst_pkg.sv
`timescale 1ns/1ps
package mst_pkg;

    localparam int unsigned MST_LINES_DEF = 8;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic ring;
        logic car;
        logic conn;
    } line_state_t;

    // line is hung up when its ready bit falls while connected
    function automatic logic ready_fell(input logic was_rdy, input logic now_rdy);
        return was_rdy & ~now_rdy;
    endfunction

    // arrival is accepted only on an idle line with no leave pending
    function automatic logic fresh_arrival(input logic evt, input logic connected,
                                           input logic leaving);
        return evt & ~connected & ~leaving;
    endfunction

endpackage

// File: rtl/mst_ctrl_reg.sv
`timescale 1ns/1ps
module mst_ctrl_reg
    import mst_pkg::*;
#(
    parameter int unsigned NLINES = MST_LINES_DEF,
    localparam int unsigned WORD_W = 2 * NLINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              full_init,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] ctl_q,
    output logic              rdy_wr,
    output logic [NLINES-1:0] rdy_old,
    output logic [NLINES-1:0] rdy_eff
);

    reg_sel_e sel;

    always_comb begin
        sel     = reg_sel_e'(wr_sel);
        rdy_wr  = wr_en && (sel == SEL_CTRL);
        rdy_old = ctl_q[WORD_W-1:NLINES];
        rdy_eff = rdy_wr ? wr_data[WORD_W-1:NLINES] : rdy_old;
    end

    always_ff @(posedge clk) begin
        if (rst || full_init) begin
            ctl_q <= '0;
        end else if (rdy_wr) begin
            ctl_q <= wr_data;
        end
    end

endmodule

// File: rtl/mst_line_cell.sv
`timescale 1ns/1ps
module mst_line_cell
    import mst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        full_init,
    input  logic        mdm_en,
    input  logic        auto_en,
    input  logic        rdy_wr,
    input  logic        rdy_old,
    input  logic        rdy_eff,
    input  logic        conn_evt,
    input  logic        disc_evt,
    output line_state_t st_q,
    output logic        hangup_q
);

    line_state_t nxt;
    logic        drop;
    logic        fresh;
    logic        answer;
    logic        ring_t;
    logic        car_t;

    always_comb begin
        drop   = rdy_wr & mdm_en & auto_en & st_q.conn & ready_fell(rdy_old, rdy_eff);
        fresh  = fresh_arrival(conn_evt, st_q.conn, disc_evt);
        answer = rdy_wr & rdy_eff;

        nxt.conn = (st_q.conn & ~drop & ~disc_evt) | fresh;

        ring_t = st_q.ring;
        car_t  = st_q.car;
        if (mdm_en) begin
            car_t  = st_q.car | (answer & st_q.ring);
            ring_t = st_q.ring & ~answer;
            if (fresh) begin
                if (rdy_eff) begin
                    car_t = 1'b1;
                end else begin
                    ring_t = 1'b1;
                end
            end
            car_t = car_t & nxt.conn;
        end
        nxt.ring = ring_t;
        nxt.car  = car_t;
    end

    always_ff @(posedge clk) begin
        if (rst || full_init) begin
            st_q     <= '0;
            hangup_q <= 1'b0;
        end else begin
            st_q     <= nxt;
            hangup_q <= drop;
        end
    end

endmodule

// File: rtl/mst_status_pack.sv
`timescale 1ns/1ps
module mst_status_pack
    import mst_pkg::*;
#(
    parameter int unsigned NLINES = MST_LINES_DEF,
    localparam int unsigned WORD_W = 2 * NLINES
) (
    input  line_state_t [NLINES-1:0] lines,
    output logic [WORD_W-1:0]        status,
    output logic [NLINES-1:0]        conn
);

    for (genvar g = 0; g < NLINES; g++) begin : g_pack
        assign status[g]          = lines[g].ring;
        assign status[NLINES + g] = lines[g].car;
        assign conn[g]            = lines[g].conn;
    end

endmodule

// File: rtl/modem_status_tracker.sv
`timescale 1ns/1ps
module modem_status_tracker
    import mst_pkg::*;
#(
    parameter int unsigned NLINES = MST_LINES_DEF,
    localparam int unsigned WORD_W = 2 * NLINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              full_init,
    input  logic              mdm_en,
    input  logic              auto_disc_en,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [NLINES-1:0] conn_evt,
    input  logic [NLINES-1:0] disc_evt,
    output logic [WORD_W-1:0] ctl_q,
    output logic [WORD_W-1:0] status_q,
    output logic [NLINES-1:0] conn_q,
    output logic [NLINES-1:0] hangup
);

    logic                     rdy_wr;
    logic [NLINES-1:0]        rdy_old;
    logic [NLINES-1:0]        rdy_eff;
    line_state_t [NLINES-1:0] lines;

    mst_ctrl_reg #(.NLINES(NLINES)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .full_init (full_init),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ctl_q     (ctl_q),
        .rdy_wr    (rdy_wr),
        .rdy_old   (rdy_old),
        .rdy_eff   (rdy_eff)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        mst_line_cell i_cell (
            .clk       (clk),
            .rst       (rst),
            .full_init (full_init),
            .mdm_en    (mdm_en),
            .auto_en   (auto_disc_en),
            .rdy_wr    (rdy_wr),
            .rdy_old   (rdy_old[g]),
            .rdy_eff   (rdy_eff[g]),
            .conn_evt  (conn_evt[g]),
            .disc_evt  (disc_evt[g]),
            .st_q      (lines[g]),
            .hangup_q  (hangup[g])
        );
    end

    mst_status_pack #(.NLINES(NLINES)) i_pack (
        .lines  (lines),
        .status (status_q),
        .conn   (conn_q)
    );

endmodule

// File: rtl/mst_checker.sv
`timescale 1ns/1ps
module mst_checker #(
    parameter int unsigned NLINES = 8,
    localparam int unsigned WORD_W = 2 * NLINES
) (
    input logic              clk,
    input logic              rst,
    input logic              full_init,
    input logic              mdm_en,
    input logic              auto_disc_en,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] ctl_q,
    input logic [WORD_W-1:0] status_q,
    input logic [NLINES-1:0] conn_q,
    input logic [NLINES-1:0] hangup
);

    p_ctl_store_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && !full_init) |=> (ctl_q == $past(wr_data)));

    p_ring_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && mdm_en && !full_init) |=>
        ((status_q[NLINES-1:0] & $past(wr_data[WORD_W-1:NLINES])) == '0));

    p_hang_cause_r5: assert property (@(posedge clk) disable iff (rst)
        (|hangup) |-> $past(auto_disc_en && mdm_en && wr_en && !wr_sel));

    p_hang_line_down_r5: assert property (@(posedge clk) disable iff (rst)
        (|hangup) |-> ((hangup & conn_q) == '0));

    p_hang_single_r5: assert property (@(posedge clk) disable iff (rst)
        (|hangup) |=> ((hangup & $past(hangup)) == '0));

    p_car_needs_conn_r7: assert property (@(posedge clk) disable iff (rst)
        mdm_en |=> ((status_q[WORD_W-1:NLINES] & ~conn_q) == '0));

    p_stat_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (!mdm_en && !full_init) |=> $stable(status_q));

    p_init_clear_r10: assert property (@(posedge clk) disable iff (rst)
        full_init |=> (status_q == '0 && conn_q == '0 && hangup == '0 && ctl_q == '0));

endmodule

bind modem_status_tracker mst_checker #(.NLINES(NLINES)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .full_init    (full_init),
    .mdm_en       (mdm_en),
    .auto_disc_en (auto_disc_en),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .ctl_q        (ctl_q),
    .status_q     (status_q),
    .conn_q       (conn_q),
    .hangup       (hangup)
);

// File: tb/test_modem_status_tracker.sv
`timescale 1ns/1ps
module test_modem_status_tracker;

    typedef struct packed {
        logic        wr;
        logic        sel;
        logic        mdm;
        logic        aut;
        logic [15:0] data;
        logic [7:0]  cev;
        logic [7:0]  dev;
        logic [15:0] est;
        logic [7:0]  econ;
        logic [7:0]  ehang;
        logic [15:0] ectl;
        logic [7:0]  req;
    } vec_t;

    function automatic vec_t mk(input logic wr, input logic sel, input logic mdm,
                                input logic aut, input logic [15:0] data,
                                input logic [7:0] cev, input logic [7:0] dev,
                                input logic [15:0] est, input logic [7:0] econ,
                                input logic [7:0] ehang, input logic [15:0] ectl,
                                input logic [7:0] req);
        vec_t v;
        v = {wr, sel, mdm, aut, data, cev, dev, est, econ, ehang, ectl, req};
        return v;
    endfunction

    localparam int NV = 14;
    localparam vec_t VT [0:NV-1] = '{
        // R6: arrival, ready low -> ring
        mk(0,0,1,1,16'h0000,8'h01,8'h00, 16'h0001,8'h01,8'h00,16'h0000, 6),
        // R3 R4 R2: answer ring on line 0, low byte stored too
        mk(1,0,1,1,16'h01A5,8'h00,8'h00, 16'h0100,8'h01,8'h00,16'h01A5, 3),
        // R6: second arrival rings line 1
        mk(0,0,1,1,16'h0000,8'h02,8'h00, 16'h0102,8'h03,8'h00,16'h01A5, 6),
        // R6: arrival on line 2 with ready raised in same cycle -> carrier
        mk(1,0,1,1,16'h0500,8'h04,8'h00, 16'h0502,8'h07,8'h00,16'h0500, 6),
        // R6: arrival on connected line 0 ignored
        mk(0,0,1,1,16'h0000,8'h01,8'h00, 16'h0502,8'h07,8'h00,16'h0500, 6),
        // R5: line 0 ready falls -> hangup
        mk(1,0,1,1,16'h0400,8'h00,8'h00, 16'h0402,8'h06,8'h01,16'h0400, 5),
        // R5: pulse gone next cycle
        mk(0,0,1,1,16'h0000,8'h00,8'h00, 16'h0402,8'h06,8'h00,16'h0400, 5),
        // R5: auto-disconnect off, ready falls, no hangup
        mk(1,0,1,0,16'h0000,8'h00,8'h00, 16'h0402,8'h06,8'h00,16'h0000, 5),
        // R7: leave on line 2 clears carrier
        mk(0,0,1,1,16'h0000,8'h00,8'h04, 16'h0002,8'h02,8'h00,16'h0000, 7),
        // R8: modem control off, write stored, no answer
        mk(1,0,0,1,16'h0200,8'h00,8'h00, 16'h0002,8'h02,8'h00,16'h0200, 8),
        // R8: modem control off, arrival connects without ring
        mk(0,0,0,1,16'h0000,8'h08,8'h00, 16'h0002,8'h0A,8'h00,16'h0200, 8),
        // R9: write to status address ignored
        mk(1,1,1,1,16'hFFFF,8'h00,8'h00, 16'h0002,8'h0A,8'h00,16'h0200, 9),
        // R11: arrival and leave together on line 4
        mk(0,0,1,1,16'h0000,8'h10,8'h10, 16'h0002,8'h0A,8'h00,16'h0200, 11),
        // R3: rewrite same ready answers pending ring on line 1
        mk(1,0,1,1,16'h0200,8'h00,8'h00, 16'h0200,8'h0A,8'h00,16'h0200, 3)
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        full_init = 1'b0;
    logic        mdm_en = 1'b0;
    logic        auto_disc_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  conn_evt = '0;
    logic [7:0]  disc_evt = '0;
    logic [15:0] ctl_q;
    logic [15:0] status_q;
    logic [7:0]  conn_q;
    logic [7:0]  hangup;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    modem_status_tracker #(.NLINES(8)) i_modem_status_tracker (
        .clk          (clk),
        .rst          (rst),
        .full_init    (full_init),
        .mdm_en       (mdm_en),
        .auto_disc_en (auto_disc_en),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .conn_evt     (conn_evt),
        .disc_evt     (disc_evt),
        .ctl_q        (ctl_q),
        .status_q     (status_q),
        .conn_q       (conn_q),
        .hangup       (hangup)
    );

    task automatic chk(input string what, input int req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en    = 1'b0;
        wr_sel   = 1'b0;
        wr_data  = '0;
        conn_evt = '0;
        disc_evt = '0;
        full_init = 1'b0;
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("reset status", 1, status_q, 16'h0000);
        chk("reset conn", 1, {8'h00, conn_q}, 16'h0000);
        chk("reset hangup", 1, {8'h00, hangup}, 16'h0000);
        chk("reset ctl", 1, ctl_q, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            wr_en        = VT[i].wr;
            wr_sel       = VT[i].sel;
            mdm_en       = VT[i].mdm;
            auto_disc_en = VT[i].aut;
            wr_data      = VT[i].data;
            conn_evt     = VT[i].cev;
            disc_evt     = VT[i].dev;
            @(posedge clk);
            @(negedge clk);
            idle_inputs();
            chk($sformatf("vec %0d status", i), int'(VT[i].req), status_q, VT[i].est);
            chk($sformatf("vec %0d conn", i), int'(VT[i].req), {8'h00, conn_q}, {8'h00, VT[i].econ});
            chk($sformatf("vec %0d hangup", i), int'(VT[i].req), {8'h00, hangup}, {8'h00, VT[i].ehang});
            chk($sformatf("vec %0d ctl", i), int'(VT[i].req), ctl_q, VT[i].ectl);
        end

        // R10: full initialization from a busy state
        mdm_en    = 1'b1;
        full_init = 1'b1;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        chk("init status", 10, status_q, 16'h0000);
        chk("init conn", 10, {8'h00, conn_q}, 16'h0000);
        chk("init hangup", 10, {8'h00, hangup}, 16'h0000);
        chk("init ctl", 10, ctl_q, 16'h0000);

        // R1: ring of line 7 lands at bit 7, its carrier at bit 15
        conn_evt = 8'h80;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        chk("line7 ring position", 1, status_q, 16'h0080);
        wr_en   = 1'b1;
        wr_data = 16'h8000;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        chk("line7 carrier position", 1, status_q, 16'h8000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule